// File: doc/BRIEF.md
# Nested Interrupt Acknowledge and Completion Tracker

This block runs the acknowledge and completion handshake of one processor's interrupt interface when interrupts nest. Selection logic elsewhere presents the best pending candidate, with its ID and priority. When the processor reads the acknowledge strobe, the block either accepts that candidate or answers with the null ID 1023. On acceptance it asks the state block to clear the candidate's pending bit. The candidate then becomes the running interrupt, and its priority becomes the running priority.

Each accepted interrupt remembers which interrupt was running before it, and at which priority. These records form a chain from the running interrupt down to the idle state. A completion write names an interrupt ID. If that ID is the running one, the chain is popped in a single cycle. If it is deeper in the chain, a small state machine walks the chain one link per cycle and splices the entry out. While the walk runs, the block is busy and drops new strobes. A level-sensitive interrupt whose line is still high when it is completed is reported back as pending again.

Top module: `irq_ack_eoi_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 2^PRIO_W (256 by default), busy is low and no valid strobe is raised. The running ID equals 1023 exactly when the running priority equals 2^PRIO_W.
- R2: An accepted acknowledge answers with ack_id 1023, and changes nothing else, when cand_id is 1023 or not below NUM_IRQ, or when cand_prio is not strictly below the running priority.
- R3: A successful acknowledge pulses ack_vld with ack_id equal to cand_id, and pulses pclr_vld with the same ID, one cycle after the strobe. In that same cycle run_id becomes cand_id and run_prio becomes cand_prio.
- R4: A completion whose ID equals the running ID restores, one cycle later, the running ID and running priority that were current when that interrupt was acknowledged. Completing the last entry of the chain returns to 1023 and 2^PRIO_W.
- R5: A completion written while the running ID is 1023 has no effect: no pset_vld is raised and the running state is unchanged.
- R6: An accepted completion of an ID below NUM_IRQ whose irq_edge bit is 0, irq_en bit is 1 and irq_lvl bit is 1 pulses pset_vld with that ID one cycle later. The other combinations raise nothing.
- R7: A completion of an ID that is not running leaves run_id and run_prio unchanged. It raises busy for one cycle per chain link examined, and splices the named entry out of the chain so that later pops skip it. A completion of 1023, or of an ID that is not in the chain, walks to the end of the chain and changes nothing.
- R8: A walk stops after WALK_LIMIT links even if the chain never ends.
- R9: While busy is high, acknowledge and completion strobes are dropped without a response. A completion strobe that arrives in the same cycle as an acknowledge strobe is dropped.
- R10: Only the low 10 bits of eoi_data form the completed ID. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_rd | input | 1 | Acknowledge read strobe |
| cand_id | input | 10 | Best pending interrupt ID from selection logic (1023 = none) |
| cand_prio | input | PRIO_W | Priority of cand_id (lower value = more urgent) |
| eoi_wr | input | 1 | Completion write strobe |
| eoi_data | input | DATA_W | Completion write data; bits [9:0] carry the ID |
| irq_edge | input | NUM_IRQ | Per-interrupt trigger type, 1 = edge |
| irq_en | input | NUM_IRQ | Per-interrupt enable |
| irq_lvl | input | NUM_IRQ | Per-interrupt current input level |
| ack_vld | output | 1 | Acknowledge response valid |
| ack_id | output | 10 | Acknowledge response ID |
| pclr_vld | output | 1 | Request to clear a pending bit |
| pclr_id | output | 10 | ID whose pending bit is to be cleared |
| pset_vld | output | 1 | Request to set a pending bit again |
| pset_id | output | 10 | ID whose pending bit is to be set |
| run_id | output | 10 | Running interrupt ID |
| run_prio | output | PRIO_W+1 | Running priority |
| busy | output | 1 | Chain walk in progress |

## Verification
The bench builds the block with NUM_IRQ=16, PRIO_W=8 and WALK_LIMIT=16. With these values the candidate IDs from 16 to 1022 fall out of range and can be used as ineligible candidates, and a deliberately looped chain runs into the walk limit within sixteen cycles. Re-acknowledging the running ID at a lower priority creates that self-loop. A behavioural model tracks the chain with integer arrays and checks every output on every cycle. The model covers nested acknowledges, pops from the head, splices from the middle and the tail, walks for missing IDs, and strobes dropped while busy.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/irq_link_table.sv
module irq_link_table
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int PRIO_W  = 8,
  parameter int NRD     = 3
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [ID_W-1:0]                wr_addr,
  input  logic [ID_W-1:0]                wr_link,
  input  logic [PRIO_W:0]                wr_prio,
  input  logic [NRD-1:0][ID_W-1:0]       rd_addr,
  output logic [NRD-1:0][ID_W-1:0]       rd_link,
  output logic [NRD-1:0][PRIO_W:0]       rd_prio
);
  localparam int AW = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] N_ID = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  // link to the interrupt that was running before, and the priority it ran at
  logic [ID_W-1:0] link_mem [NUM_IRQ];
  logic [PRIO_W:0] prio_mem [NUM_IRQ];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < N_ID)) begin
      link_mem[wr_addr[AW-1:0]] <= wr_link;
      prio_mem[wr_addr[AW-1:0]] <= wr_prio;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_addr[p] < N_ID) begin
        rd_link[p] = link_mem[rd_addr[p][AW-1:0]];
        rd_prio[p] = prio_mem[rd_addr[p][AW-1:0]];
      end else begin
        rd_link[p] = NONE_ID;
        rd_prio[p] = IDLE_PRIO;
      end
    end
  end
endmodule

// File: rtl/eoi_chain_walker.sv
module eoi_chain_walker
  import irq_trk_pkg::*;
#(
  parameter int PRIO_W     = 8,
  parameter int WALK_LIMIT = 96
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ID_W-1:0] start_id,
  input  logic [ID_W-1:0] target_in,
  input  logic [ID_W-1:0] cur_link,
  input  logic [ID_W-1:0] tgt_link,
  input  logic [PRIO_W:0] tgt_prio,
  output logic            busy,
  output logic [ID_W-1:0] cur_id,
  output logic [ID_W-1:0] tgt_id,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_addr,
  output logic [ID_W-1:0] wr_link,
  output logic [PRIO_W:0] wr_prio
);
  localparam int SW = $clog2(WALK_LIMIT + 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(WALK_LIMIT - 1);
  localparam logic [SW-1:0] LIMIT_V   = SW'(WALK_LIMIT);

  walk_state_e     state;
  logic [SW-1:0]   steps;
  logic            at_end;
  logic            found;

  assign at_end = (cur_link == NONE_ID);
  assign found  = !at_end && (cur_link == tgt_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WK_IDLE;
      cur_id <= NONE_ID;
      tgt_id <= NONE_ID;
      steps  <= '0;
    end else begin
      case (state)
        WK_IDLE: begin
          if (start) begin
            state  <= WK_RUN;
            cur_id <= start_id;
            tgt_id <= target_in;
            steps  <= '0;
          end
        end
        WK_RUN: begin
          if (at_end || found || (steps == LAST_STEP)) begin
            state <= WK_IDLE;
          end else begin
            cur_id <= cur_link;
            steps  <= steps + 1'b1;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign busy    = (state == WK_RUN);
  assign wr_en   = (state == WK_RUN) && found;
  assign wr_addr = cur_id;
  assign wr_link = tgt_link;
  assign wr_prio = tgt_prio;

  // R8
  walk_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == WK_RUN) |-> (steps < LIMIT_V));

  // R7
  walk_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/eoi_repend_check.sv
module eoi_repend_check
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic [ID_W-1:0]    id,
  input  logic [NUM_IRQ-1:0] irq_edge,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  output logic               hit
);
  localparam int AW = $clog2(NUM_IRQ);
  localparam logic [ID_W-1:0] N_ID = ID_W'(NUM_IRQ);

  always_comb begin
    hit = 1'b0;
    if (id < N_ID) begin
      hit = !irq_edge[id[AW-1:0]] && irq_en[id[AW-1:0]] && irq_lvl[id[AW-1:0]];
    end
  end
endmodule

// File: rtl/irq_ack_eoi_tracker.sv
module irq_ack_eoi_tracker
  import irq_trk_pkg::*;
#(
  parameter int NUM_IRQ    = 96,
  parameter int PRIO_W     = 8,
  parameter int DATA_W     = 32,
  parameter int WALK_LIMIT = 96
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_rd,
  input  logic [9:0]         cand_id,
  input  logic [PRIO_W-1:0]  cand_prio,
  input  logic               eoi_wr,
  input  logic [DATA_W-1:0]  eoi_data,
  input  logic [NUM_IRQ-1:0] irq_edge,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  output logic               ack_vld,
  output logic [9:0]         ack_id,
  output logic               pclr_vld,
  output logic [9:0]         pclr_id,
  output logic               pset_vld,
  output logic [9:0]         pset_id,
  output logic [9:0]         run_id,
  output logic [PRIO_W:0]    run_prio,
  output logic               busy
);
  localparam logic [ID_W-1:0] N_ID = ID_W'(NUM_IRQ);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic [ID_W-1:0] eoi_id;
  logic            eoi_unused_bits;
  logic            ack_go, ack_ok, eoi_go, eoi_pop, walk_start, repend_hit;

  logic [2:0][ID_W-1:0] rd_addr;
  logic [2:0][ID_W-1:0] rd_link;
  logic [2:0][PRIO_W:0] rd_prio;

  logic            tb_we;
  logic [ID_W-1:0] tb_waddr, tb_wlink;
  logic [PRIO_W:0] tb_wprio;

  logic            w_busy, w_we;
  logic [ID_W-1:0] w_cur, w_tgt, w_addr, w_link;
  logic [PRIO_W:0] w_prio;

  assign eoi_id          = eoi_data[ID_W-1:0];
  assign eoi_unused_bits = ^eoi_data[DATA_W-1:ID_W];

  assign ack_go     = ack_rd && !w_busy;
  assign ack_ok     = ack_go && (cand_id < N_ID) && ({1'b0, cand_prio} < run_prio);
  assign eoi_go     = eoi_wr && !ack_rd && !w_busy && (run_id != NONE_ID);
  assign eoi_pop    = eoi_go && (eoi_id == run_id);
  assign walk_start = eoi_go && !eoi_pop;

  // port 0: head of chain, port 1: walk cursor, port 2: walk target
  assign rd_addr[0] = run_id;
  assign rd_addr[1] = w_cur;
  assign rd_addr[2] = w_tgt;

  assign tb_we    = ack_ok || w_we;
  assign tb_waddr = ack_ok ? cand_id  : w_addr;
  assign tb_wlink = ack_ok ? run_id   : w_link;
  assign tb_wprio = ack_ok ? run_prio : w_prio;

  irq_link_table #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .NRD     (3)
  ) u_table (
    .clk     (clk),
    .wr_en   (tb_we),
    .wr_addr (tb_waddr),
    .wr_link (tb_wlink),
    .wr_prio (tb_wprio),
    .rd_addr (rd_addr),
    .rd_link (rd_link),
    .rd_prio (rd_prio)
  );

  eoi_chain_walker #(
    .PRIO_W     (PRIO_W),
    .WALK_LIMIT (WALK_LIMIT)
  ) u_walker (
    .clk       (clk),
    .rst       (rst),
    .start     (walk_start),
    .start_id  (run_id),
    .target_in (eoi_id),
    .cur_link  (rd_link[1]),
    .tgt_link  (rd_link[2]),
    .tgt_prio  (rd_prio[2]),
    .busy      (w_busy),
    .cur_id    (w_cur),
    .tgt_id    (w_tgt),
    .wr_en     (w_we),
    .wr_addr   (w_addr),
    .wr_link   (w_link),
    .wr_prio   (w_prio)
  );

  eoi_repend_check #(
    .NUM_IRQ (NUM_IRQ)
  ) u_repend (
    .id       (eoi_id),
    .irq_edge (irq_edge),
    .irq_en   (irq_en),
    .irq_lvl  (irq_lvl),
    .hit      (repend_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_vld  <= 1'b0;
      ack_id   <= NONE_ID;
      pclr_vld <= 1'b0;
      pclr_id  <= NONE_ID;
      pset_vld <= 1'b0;
      pset_id  <= NONE_ID;
      run_id   <= NONE_ID;
      run_prio <= IDLE_PRIO;
    end else begin
      ack_vld  <= ack_go;
      pclr_vld <= ack_ok;
      pset_vld <= eoi_go && repend_hit;
      if (ack_go) ack_id <= ack_ok ? cand_id : NONE_ID;
      if (ack_ok) pclr_id <= cand_id;
      if (eoi_go && repend_hit) pset_id <= eoi_id;
      if (ack_ok) begin
        run_id   <= cand_id;
        run_prio <= {1'b0, cand_prio};
      end else if (eoi_pop) begin
        run_id   <= rd_link[0];
        run_prio <= rd_prio[0];
      end
    end
  end

  assign busy = w_busy;

  // R1
  idle_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (run_id == NONE_ID) == (run_prio == IDLE_PRIO));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_id != NONE_ID) |-> (pclr_vld && pclr_id == ack_id && run_id == ack_id));

  // R3
  prio_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_id != NONE_ID) |-> (run_prio < $past(run_prio)));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!ack_vld && !pset_vld));

  // R5
  idle_eoi_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_wr && !ack_rd && run_id == NONE_ID) |=> (!pset_vld && run_id == NONE_ID));

  // R6
  pset_src_chk: assert property (@(posedge clk) disable iff (rst)
    pset_vld |-> ($past(eoi_wr) && pset_id < N_ID));
endmodule

// File: tb/irq_ack_eoi_tracker_bench.sv
`timescale 1ns/1ps
module irq_ack_eoi_tracker_bench;
  localparam int N   = 16;
  localparam int PW  = 8;
  localparam int LIM = 16;

  logic           clk = 1'b0;
  logic           rst;
  logic           ack_rd, eoi_wr;
  logic [9:0]     cand_id;
  logic [PW-1:0]  cand_prio;
  logic [31:0]    eoi_data;
  logic [N-1:0]   irq_edge, irq_en, irq_lvl;
  logic           ack_vld, pclr_vld, pset_vld, busy;
  logic [9:0]     ack_id, pclr_id, pset_id, run_id;
  logic [PW:0]    run_prio;

  always #4 clk = ~clk;

  irq_ack_eoi_tracker #(
    .NUM_IRQ(N), .PRIO_W(PW), .DATA_W(32), .WALK_LIMIT(LIM)
  ) u_irq_ack_eoi_tracker (
    .clk(clk), .rst(rst), .ack_rd(ack_rd), .cand_id(cand_id), .cand_prio(cand_prio),
    .eoi_wr(eoi_wr), .eoi_data(eoi_data), .irq_edge(irq_edge), .irq_en(irq_en),
    .irq_lvl(irq_lvl), .ack_vld(ack_vld), .ack_id(ack_id), .pclr_vld(pclr_vld),
    .pclr_id(pclr_id), .pset_vld(pset_vld), .pset_id(pset_id), .run_id(run_id),
    .run_prio(run_prio), .busy(busy)
  );

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  string cur_req = "R1";
  bit    armed = 0;

  // behavioural model
  int m_link [N];
  int m_sav  [N];
  int m_run, m_prio, m_busy;
  int e_ackv, e_ackid, e_pclrv, e_pclrid, e_psetv, e_psetid;
  int c, n, cur, lnk, nr;
  bit was_busy, done;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      m_run = 1023; m_prio = 1 << PW; m_busy = 0;
      e_ackv = 0; e_pclrv = 0; e_psetv = 0;
    end else begin
      e_ackv = 0; e_pclrv = 0; e_psetv = 0;
      was_busy = (m_busy > 0);
      if (m_busy > 0) m_busy--;
      if (!was_busy && ack_rd) begin
        e_ackv = 1;
        if (int'(cand_id) < N && int'(cand_prio) < m_prio) begin
          c = int'(cand_id);
          e_ackid = c; e_pclrv = 1; e_pclrid = c;
          m_link[c] = m_run; m_sav[c] = m_prio;
          m_run = c; m_prio = int'(cand_prio);
        end else begin
          e_ackid = 1023;
        end
      end else if (!was_busy && eoi_wr && m_run != 1023) begin
        c = int'(eoi_data & 32'h3ff);
        if (c < N && !irq_edge[c] && irq_en[c] && irq_lvl[c]) begin
          e_psetv = 1; e_psetid = c;
        end
        if (c == m_run) begin
          nr = m_link[m_run];
          m_prio = m_sav[m_run];
          m_run = nr;
        end else begin
          n = 0; cur = m_run; done = 0;
          while (!done) begin
            n++;
            lnk = m_link[cur];
            if (lnk == 1023) done = 1;
            else if (lnk == c) begin
              m_link[cur] = m_link[c]; m_sav[cur] = m_sav[c]; done = 1;
            end else if (n == LIM) done = 1;
            else cur = lnk;
          end
          m_busy = n;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("ack_vld", int'(ack_vld), e_ackv);
      if (e_ackv != 0) chk("ack_id", int'(ack_id), e_ackid);
      chk("pclr_vld", int'(pclr_vld), e_pclrv);
      if (e_pclrv != 0) chk("pclr_id", int'(pclr_id), e_pclrid);
      chk("pset_vld", int'(pset_vld), e_psetv);
      if (e_psetv != 0) chk("pset_id", int'(pset_id), e_psetid);
      chk("run_id", int'(run_id), m_run);
      chk("run_prio", int'(run_prio), m_prio);
      chk("busy", int'(busy), int'(m_busy > 0));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_ack(input int id, input int pr);
    ack_rd = 1'b1; cand_id = 10'(id); cand_prio = PW'(pr);
    @(negedge clk);
    ack_rd = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic do_eoi(input logic [31:0] d);
    eoi_wr = 1'b1; eoi_data = d;
    @(negedge clk);
    eoi_wr = 1'b0;
    @(negedge clk);
    wait_idle();
  endtask

  initial begin
    rst = 1'b1; ack_rd = 1'b0; eoi_wr = 1'b0; cand_id = '0; cand_prio = '0;
    eoi_data = '0; irq_edge = '0; irq_en = '0; irq_lvl = '0;
    irq_edge[9] = 1'b1; irq_en[9] = 1'b1; irq_lvl[9] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R2";
    do_ack(1023, 5);
    do_ack(20, 5);

    cur_req = "R3";
    do_ack(3, 'h40);
    cur_req = "R2";
    do_ack(5, 'h40);
    cur_req = "R3";
    do_ack(5, 'h20);
    do_ack(9, 'h10);

    cur_req = "R9";
    ack_rd = 1'b1; cand_id = 10'd2; cand_prio = 8'h50;
    eoi_wr = 1'b1; eoi_data = 32'd9;
    @(negedge clk);
    ack_rd = 1'b0; eoi_wr = 1'b0;
    @(negedge clk);

    cur_req = "R7";
    irq_en[5] = 1'b1; irq_lvl[5] = 1'b1;
    eoi_wr = 1'b1; eoi_data = 32'd5;
    @(negedge clk);
    eoi_wr = 1'b0;
    cur_req = "R9";
    ack_rd = 1'b1; cand_id = 10'd1; cand_prio = 8'h01;
    @(negedge clk);
    ack_rd = 1'b0;
    wait_idle();
    @(negedge clk);

    cur_req = "R4";
    irq_en[3] = 1'b1; irq_lvl[3] = 1'b1;
    do_eoi(32'd9);
    cur_req = "R6";
    do_eoi(32'd3);

    cur_req = "R5";
    do_eoi(32'd3);

    cur_req = "R7";
    do_ack(1, 'h80);
    do_ack(2, 'h60);
    do_ack(4, 'h50);
    do_ack(6, 'h30);
    do_eoi(32'd1);
    do_eoi(32'd7);
    do_eoi(32'd1023);

    cur_req = "R10";
    do_eoi(32'hABCD_FC06);

    cur_req = "R4";
    do_eoi(32'd4);
    do_eoi(32'd2);

    cur_req = "R8";
    do_ack(5, 'h20);
    do_ack(5, 'h10);
    do_eoi(32'd7);

    cur_req = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule